// File: doc/BRIEF.md
# Serial Control Register Port

This block is the control port of a sensor analog front-end. A host programs it over three pins: an active-low load strobe, a serial clock and a data line. The block oversamples all three pins in the system clock domain. A transfer opens when the strobe falls. Each rising serial clock edge then samples one bit. The frame holds a 3-bit address, a read flag and up to ten data bits, each field least significant bit first.

Writes update one of five control registers, and each write commits when the strobe rises. One register packs five 2-bit mode fields. The others are a 10-bit gain code, two 8-bit codes for the auxiliary converters, and a 2-bit enable register. A read frame returns the addressed register on a serial output with a separate output enable. All fields are exported as plain level outputs to the rest of the chip. The power mode is also exported as decoded flags.

The serial pins are control signals with no back-pressure. The host keeps each serial clock phase at least four system clock cycles long, so that every edge is seen.

Top module: `ser_ctl_port`

## Requirements
- R1: While `ser_load_n` is low, rising edges of `ser_clk` sample `ser_din` in this order: address bits 0, 1, 2, then the read flag, then data bits 0 to 9.
- R2: A write has the read flag at 0. It updates its register on the rising edge of `ser_load_n`, and only if all ten data bits were clocked in. A write with fewer bits changes nothing.
- R3: After the 14th rising clock edge of a transfer, further clock edges are ignored. They do not alter the captured frame.
- R4: When `op_mode` is 00 (auxiliary mode), a gain write with eight or more data bits commits. Data bits that were not sent load as zero. Fewer than eight data bits change nothing. In any other operating mode, a gain write needs all ten bits.
- R5: The mode register sits at address 010. Data bits 1:0 set `clamp_lvl`, bits 3:2 set `pwr_mode`, bits 5:4 set `clk_mode`, bits 7:6 set `out_mode` and bits 9:8 set `op_mode`.
- R6: After reset, every register field is zero except `op_mode`, which is 11 (CCD mode). This leaves `dac_enable` at 0.
- R7: Gain is at address 000 and uses data bits 9:0. Converter 1 is at 100 and converter 2 is at 110; both take data bits 7:0. The enable register is at 001: bit 0 is `dac_enable` and bit 1 is `eo_corr_bypass`. Writes to any other address change nothing.
- R8: A read frame has the read flag at 1. On the first falling clock edge after the flag is sampled, `ser_dout_en` rises and `ser_dout` shows data bit 0. Each following falling edge moves to the next bit, for ten bits. The register contents are zero-extended, and unmapped addresses read as zero. `ser_dout_en` is low outside reads, and a read changes no register.
- R9: The power flags decode `pwr_mode`: 00 sets no flag, 01 sets `pd_hs_aux`, 10 sets `pd_ref_stby` and 11 sets `pd_shutdown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_load_n | input | 1 | Transfer strobe, low during a frame |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial read data |
| ser_dout_en | output | 1 | Drive enable for `ser_dout` |
| clamp_lvl | output | 2 | Clamp level field |
| pwr_mode | output | 2 | Power mode field |
| clk_mode | output | 2 | Clock mode field |
| out_mode | output | 2 | Output mode field |
| op_mode | output | 2 | Operating mode field (00 auxiliary, 11 CCD) |
| pd_hs_aux | output | 1 | High-speed auxiliary power mode flag |
| pd_ref_stby | output | 1 | Reference standby flag |
| pd_shutdown | output | 1 | Total shutdown flag |
| gain_code | output | 10 | Gain code |
| dac1_code | output | 8 | Converter 1 code |
| dac2_code | output | 8 | Converter 2 code |
| dac_enable | output | 1 | Auxiliary converters operational |
| eo_corr_bypass | output | 1 | Even/odd offset correction not used |

## Verification
The in-module assertions check the cycle-level rules on every cycle:
- the bit counter never passes fourteen, and the frame stays frozen once it is full;
- a commit never happens with fewer than the short-write bit count;
- an unmapped write or an idle cycle leaves every register unchanged;
- the read enable only rises in a read frame and drops when the strobe rises;
- the register fields hold their reset values as reset is released.

Only the bench scenarios show the rest, at the pins:
- the packing of the bit fields;
- which address reaches which register;
- the exact bit order on the read pin;
- the mode-dependent eight-bit gain writes;
- that truncated frames are discarded.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 10;
  localparam int SHORT_W = 8;
  localparam int CODE_W  = 8;
  localparam int FRAME_W = ADDR_W + 1 + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t ADR_GAIN = 3'b000;
  localparam addr_t ADR_MISC = 3'b001;
  localparam addr_t ADR_MODE = 3'b010;
  localparam addr_t ADR_DAC1 = 3'b100;
  localparam addr_t ADR_DAC2 = 3'b110;

  typedef enum logic [1:0] {
    OP_AUX    = 2'b00,
    OP_AUXMID = 2'b01,
    OP_DIRECT = 2'b10,
    OP_CCD    = 2'b11
  } op_mode_e;

  // packed: clamp occupies bits 1:0, op occupies bits 9:8
  typedef struct packed {
    op_mode_e   op;
    logic [1:0] outm;
    logic [1:0] clkm;
    logic [1:0] pwr;
    logic [1:0] clamp;
  } mode_reg_t;
endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] lvl_o
);
  logic [N-1:0] pipe_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= RST_VAL;
        else if (s == 0) pipe_q[s] <= pins_i;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx
  import ser_ctl_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int D_W = DATA_W,
  parameter int S_W = SHORT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_lvl,
  input  logic           load_lvl,
  input  logic           sdin_lvl,
  input  logic           gain_short,
  input  logic [D_W-1:0] rd_data,
  output logic           wr_en,
  output logic [A_W-1:0] wr_addr,
  output logic [D_W-1:0] wr_data,
  output logic [A_W-1:0] rd_addr,
  output logic           sdo,
  output logic           sdo_en
);
  localparam int F_W = A_W + 1 + D_W;
  localparam int C_W = $clog2(F_W + 1);
  localparam logic [C_W-1:0] CNT_FULL  = C_W'(F_W);
  localparam logic [C_W-1:0] CNT_SHORT = C_W'(A_W + 1 + S_W);
  localparam logic [C_W-1:0] CNT_HDR   = C_W'(A_W + 1);
  localparam logic [C_W-1:0] BITS_RD   = C_W'(D_W);

  logic           sclk_d, load_d;
  logic           sclk_rise, sclk_fall, load_fall, load_rise;
  logic [C_W-1:0] cnt_q, rd_idx_q;
  logic [F_W-1:0] frame_q;
  logic           rd_frame;
  logic [C_W-1:0] need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      load_d <= 1'b1;
    end else begin
      sclk_d <= sclk_lvl;
      load_d <= load_lvl;
    end
  end

  assign sclk_rise = sclk_lvl & ~sclk_d;
  assign sclk_fall = ~sclk_lvl & sclk_d;
  assign load_fall = ~load_lvl & load_d;
  assign load_rise = load_lvl & ~load_d;
  assign rd_frame  = frame_q[A_W] && (cnt_q >= CNT_HDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rd_idx_q <= '0;
      frame_q  <= '0;
      sdo      <= 1'b0;
      sdo_en   <= 1'b0;
    end else if (load_fall) begin
      cnt_q    <= '0;
      rd_idx_q <= '0;
      frame_q  <= '0;
      sdo_en   <= 1'b0;
    end else if (load_rise) begin
      sdo_en <= 1'b0;
    end else if (!load_lvl) begin
      if (sclk_rise && cnt_q < CNT_FULL) begin
        frame_q[cnt_q] <= sdin_lvl;
        cnt_q          <= cnt_q + 1'b1;
      end
      if (sclk_fall && rd_frame && rd_idx_q < BITS_RD) begin
        sdo      <= rd_data[rd_idx_q];
        sdo_en   <= 1'b1;
        rd_idx_q <= rd_idx_q + 1'b1;
      end
    end
  end

  assign rd_addr = frame_q[A_W-1:0];
  assign wr_addr = frame_q[A_W-1:0];
  assign wr_data = frame_q[F_W-1:A_W+1];
  assign need    = (gain_short && frame_q[A_W-1:0] == ADR_GAIN) ? CNT_SHORT : CNT_FULL;
  assign wr_en   = load_rise && !frame_q[A_W] && (cnt_q >= need);

  a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  a_r3_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !load_lvl && !load_fall && cnt_q == CNT_FULL) |=> $stable(frame_q));
  a_r2_commit_len: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q >= CNT_SHORT));
  a_r8_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> frame_q[A_W]);
  a_r8_oe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> !sdo_en);
endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
  import ser_ctl_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int D_W = DATA_W,
  parameter int C_W = CODE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [A_W-1:0] wr_addr,
  input  logic [D_W-1:0] wr_data,
  input  logic [A_W-1:0] rd_addr,
  output logic [D_W-1:0] rd_data,
  output mode_reg_t      mode_q,
  output logic [D_W-1:0] gain_q,
  output logic [C_W-1:0] dac1_q,
  output logic [C_W-1:0] dac2_q,
  output logic [1:0]     misc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{op: OP_CCD, default: '0};
      gain_q <= '0;
      dac1_q <= '0;
      dac2_q <= '0;
      misc_q <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADR_MODE: mode_q <= mode_reg_t'(wr_data);
        ADR_GAIN: gain_q <= wr_data;
        ADR_DAC1: dac1_q <= wr_data[C_W-1:0];
        ADR_DAC2: dac2_q <= wr_data[C_W-1:0];
        ADR_MISC: misc_q <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADR_MODE: rd_data = D_W'(mode_q);
      ADR_GAIN: rd_data = gain_q;
      ADR_DAC1: rd_data = D_W'(dac1_q);
      ADR_DAC2: rd_data = D_W'(dac2_q);
      ADR_MISC: rd_data = D_W'(misc_q);
      default:  rd_data = '0;
    endcase
  end

  logic mapped;
  assign mapped = (wr_addr == ADR_MODE) || (wr_addr == ADR_GAIN) || (wr_addr == ADR_DAC1) ||
                  (wr_addr == ADR_DAC2) || (wr_addr == ADR_MISC);

  a_r7_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(mode_q) && $stable(gain_q) && $stable(dac1_q)
                             && $stable(dac2_q) && $stable(misc_q)));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_q) && $stable(gain_q) && $stable(dac1_q)
                && $stable(dac2_q) && $stable(misc_q)));
  a_r6_reset_values: assert property (@(posedge clk)
    $rose(rst_n) |-> (mode_q.op == OP_CCD && mode_q.pwr == 2'b00 && gain_q == '0
                      && misc_q == 2'b00 && dac1_q == '0 && dac2_q == '0));
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_load_n,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_dout_en,
  output logic [1:0]        clamp_lvl,
  output logic [1:0]        pwr_mode,
  output logic [1:0]        clk_mode,
  output logic [1:0]        out_mode,
  output logic [1:0]        op_mode,
  output logic              pd_hs_aux,
  output logic              pd_ref_stby,
  output logic              pd_shutdown,
  output logic [DATA_W-1:0] gain_code,
  output logic [CODE_W-1:0] dac1_code,
  output logic [CODE_W-1:0] dac2_code,
  output logic              dac_enable,
  output logic              eo_corr_bypass
);
  logic [2:0]        pins_lvl;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  mode_reg_t         mode_q;
  logic [1:0]        misc_q;

  // pin order: {data, load, clock}; load idles high
  ser_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i ({ser_din, ser_load_n, ser_clk}),
    .lvl_o  (pins_lvl)
  );

  ser_frame_rx #(.A_W(ADDR_W), .D_W(DATA_W), .S_W(SHORT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_lvl   (pins_lvl[0]),
    .load_lvl   (pins_lvl[1]),
    .sdin_lvl   (pins_lvl[2]),
    .gain_short (mode_q.op == OP_AUX),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .sdo        (ser_dout),
    .sdo_en     (ser_dout_en)
  );

  ser_ctl_regs #(.A_W(ADDR_W), .D_W(DATA_W), .C_W(CODE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .mode_q  (mode_q),
    .gain_q  (gain_code),
    .dac1_q  (dac1_code),
    .dac2_q  (dac2_code),
    .misc_q  (misc_q)
  );

  assign clamp_lvl      = mode_q.clamp;
  assign pwr_mode       = mode_q.pwr;
  assign clk_mode       = mode_q.clkm;
  assign out_mode       = mode_q.outm;
  assign op_mode        = mode_q.op;
  assign pd_hs_aux      = (mode_q.pwr == 2'b01);
  assign pd_ref_stby    = (mode_q.pwr == 2'b10);
  assign pd_shutdown    = (mode_q.pwr == 2'b11);
  assign dac_enable     = misc_q[0];
  assign eo_corr_bypass = misc_q[1];
endmodule

// File: tb/ser_ctl_port_tb_top.sv
module ser_ctl_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_load_n = 1'b1, ser_din = 1'b0;
  logic ser_dout, ser_dout_en;
  logic [1:0] clamp_lvl, pwr_mode, clk_mode, out_mode, op_mode;
  logic pd_hs_aux, pd_ref_stby, pd_shutdown, dac_enable, eo_corr_bypass;
  logic [9:0] gain_code;
  logic [7:0] dac1_code, dac2_code;

  int nvec = 0, nfail = 0;
  bit done = 0;
  logic [9:0] exp_mode = 10'h300, exp_gain = '0;
  logic [7:0] exp_d1 = '0, exp_d2 = '0;
  logic [1:0] exp_misc = '0;

  always #5 clk = ~clk;

  ser_ctl_port dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " mode"}, {op_mode, out_mode, clk_mode, pwr_mode, clamp_lvl}, exp_mode);
    chk({tag, " gain"}, gain_code, exp_gain);
    chk({tag, " dac1"}, dac1_code, exp_d1);
    chk({tag, " dac2"}, dac2_code, exp_d2);
    chk({tag, " misc"}, {eo_corr_bypass, dac_enable}, exp_misc);
    chk({tag, " R9 pwr flags"}, {pd_shutdown, pd_ref_stby, pd_hs_aux},
        {exp_mode[3:2] == 2'b11, exp_mode[3:2] == 2'b10, exp_mode[3:2] == 2'b01});
  endtask

  task automatic wait_h();
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [2:0] a, input logic rnw, input logic [9:0] d,
                      input int edges, output logic [9:0] rb);
    rb = '0;
    ser_load_n = 1'b0;
    wait_h();
    for (int i = 0; i < edges; i++) begin
      if (i < 3) ser_din = a[i];
      else if (i == 3) ser_din = rnw;
      else if (i < 14) ser_din = d[i-4];
      else ser_din = 1'b1;
      wait_h();
      if (i >= 4 && i < 14) begin
        rb[i-4] = ser_dout;
        if (rnw) chk("R8 dout_en in read", ser_dout_en, 1);
      end
      ser_clk = 1'b1;
      wait_h();
      ser_clk = 1'b0;
    end
    wait_h();
    ser_load_n = 1'b1;
    wait_h();
    wait_h();
  endtask

  task automatic wr(input logic [2:0] a, input logic [9:0] d, input int edges);
    logic [9:0] rb;
    xfer(a, 1'b0, d, edges, rb);
  endtask

  task automatic rd_chk(string tag, input logic [2:0] a, input logic [9:0] exp);
    logic [9:0] rb;
    xfer(a, 1'b1, 10'h3FF, 14, rb);
    chk(tag, rb, exp);
    chk({tag, " oe idle"}, ser_dout_en, 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [9:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 reset state
    chk_all("R6 reset");
    chk("R8 oe after reset", ser_dout_en, 0);

    // R1/R8 gain sweep with readback
    for (int k = 0; k <= 10; k++) begin
      v = (k == 10) ? 10'h3FF : 10'(k * 101);
      wr(3'b000, v, 14);
      exp_gain = v;
      chk_all("R1 gain write");
      rd_chk("R8 gain readback", 3'b000, v);
      chk_all("R8 read no side effect");
    end

    // R2 truncated writes discarded
    for (int e = 0; e < 14; e++) begin
      wr(3'b000, 10'h2AA, e);
      chk_all("R2 truncated write");
    end

    // R3 over-length frames
    wr(3'b000, 10'h155, 20);
    exp_gain = 10'h155;
    chk_all("R3 extra edges gain");
    wr(3'b100, 10'h05A, 16);
    exp_d1 = 8'h5A;
    chk_all("R3 extra edges dac1");

    // R5/R9 mode field sweep
    for (int p = 0; p < 4; p++) begin
      v = {2'(p + 3), 2'(p + 2), 2'(p + 1), 2'(p), 2'(3 - p)};
      wr(3'b010, v, 14);
      exp_mode = v;
      chk_all("R5 mode fields");
      rd_chk("R5 mode readback", 3'b010, v);
    end

    // R4 auxiliary-mode short gain write
    wr(3'b010, 10'h004, 14);
    exp_mode = 10'h004;
    chk_all("R4 enter aux");
    wr(3'b000, 10'h3A5, 12);
    exp_gain = 10'h0A5;
    chk_all("R4 short gain write");
    wr(3'b000, 10'h3FF, 11);
    chk_all("R4 too short in aux");
    wr(3'b100, 10'h0EE, 12);
    chk_all("R4 short dac write rejected");
    wr(3'b000, 10'h301, 14);
    exp_gain = 10'h301;
    chk_all("R4 full gain in aux");
    wr(3'b010, 10'h300, 14);
    exp_mode = 10'h300;
    wr(3'b000, 10'h0C3, 12);
    chk_all("R4 short gain in CCD");

    // R7 address map
    for (int k = 0; k < 4; k++) begin
      v = 10'(k * 77 + 768);
      wr(3'b100, v, 14);
      exp_d1 = v[7:0];
      wr(3'b110, ~v, 14);
      exp_d2 = ~v[7:0];
      wr(3'b001, 10'(k), 14);
      exp_misc = 2'(k);
      chk_all("R7 map");
      rd_chk("R7 dac1 readback", 3'b100, {2'b00, exp_d1});
      rd_chk("R7 dac2 readback", 3'b110, {2'b00, exp_d2});
      rd_chk("R7 misc readback", 3'b001, {8'h00, exp_misc});
    end
    for (int a = 3; a < 8; a += 2) begin
      wr(3'(a), 10'h3FF, 14);
      chk_all("R7 unmapped write");
      rd_chk("R7 unmapped read", 3'(a), 10'h000);
    end

    done = 1;
    finish_run();
  end
endmodule